// File: doc/BRIEF.md
# Programmable Logic Output Macrocell

This block is one output cell of a small programmable logic device. It takes the sum-of-products result for its pin and a separate product term that enables the output. It also takes a global clock and a handful of static configuration bits. From these it drives the three pad signals of a tri-state I/O pin (data out, output enable and data in) and returns one feedback bit to the logic array.

The output-enable product term drives the pad enable directly. If the term is tied true, the pin is a dedicated output. If it is tied false, the pin is input only. If it is a live function, the pin is bidirectional.

A D flip-flop captures the sum result on every rising clock edge, whatever the output mode. One configuration bit chooses whether the pin is driven from the flip-flop or straight from the sum, and a second bit optionally inverts the driven value. A 2-bit selector, set independently of the output mode, chooses the feedback from one of three sources: the pad input, the flip-flop output, or the raw sum. Register and sum feedback are never inverted, and they remain usable while the pin is disabled.

Top module: `pld_out_cell`

## Requirements
- R1: While rst_ni is low, the flip-flop holds 0 at once without waiting for a clock edge. With the registered path chosen, pad_out_o then equals cfg_inv_i, and register feedback reads 0.
- R2: At each rising clk_i edge with rst_ni high, the flip-flop loads sum_i, in both output modes.
- R3: With cfg_reg_i = 0 (combinatorial path), pad_out_o equals sum_i XOR cfg_inv_i in the same cycle.
- R4: With cfg_reg_i = 1 (registered path), pad_out_o equals the flip-flop value XOR cfg_inv_i.
- R5: pad_oe_o equals oe_term_i in every configuration. A term held at 1 gives a dedicated output and a term held at 0 gives an input-only pin.
- R6: fb_sel_i = 2'b00 selects pad_in_i as feedback. The code 2'b11 is reserved and also selects pad_in_i.
- R7: fb_sel_i = 2'b01 selects the flip-flop value, not inverted, in both output modes.
- R8: fb_sel_i = 2'b10 selects sum_i directly, not inverted, whatever the output mode and oe_term_i.
- R9: pad_in_i has no effect on pad_out_o or pad_oe_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Global clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the flip-flop |
| sum_i | input | 1 | OR-gate (sum-of-products) result |
| oe_term_i | input | 1 | Output-enable product term |
| cfg_reg_i | input | 1 | 1 selects the registered output path, 0 the combinatorial path |
| cfg_inv_i | input | 1 | 1 inverts the value driven to the pad |
| fb_sel_i | input | 2 | Feedback source: 00 pad, 01 register, 10 sum, 11 pad |
| pad_in_i | input | 1 | Value read back from the pad |
| pad_out_o | output | 1 | Data driven to the pad |
| pad_oe_o | output | 1 | Pad driver enable |
| fb_o | output | 1 | Feedback to the logic array |

## Verification
A wrong flip-flop state shows one clock after the bad capture. It appears on pad_out_o when the registered path is selected, and on fb_o when register feedback is selected, even if the pad is disabled. Faults in polarity, path selection or the feedback multiplexer are purely combinational, so they show at the ports in the same cycle the stimulus is applied. The bench sweeps every combination of path, polarity, feedback code and enable against all values of sum and pad input.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;
  localparam int unsigned FB_SEL_W = 2;

  typedef enum logic [FB_SEL_W-1:0] {
    FB_PAD     = 2'b00,
    FB_FLOP    = 2'b01,
    FB_SUM     = 2'b10,
    FB_PAD_ALT = 2'b11
  } fb_src_e;
endpackage

// File: rtl/pld_cell_dff.sv
module pld_cell_dff #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RESET_VAL;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/pld_cell_drive.sv
module pld_cell_drive (
  input  logic sum_i,
  input  logic q_i,
  input  logic oe_term_i,
  input  logic cfg_reg_i,
  input  logic cfg_inv_i,
  output logic pad_out_o,
  output logic pad_oe_o
);
  logic path_val;

  always_comb begin
    path_val  = cfg_reg_i ? q_i : sum_i;
    pad_out_o = path_val ^ cfg_inv_i;
    pad_oe_o  = oe_term_i;
  end
endmodule

// File: rtl/pld_cell_fb_mux.sv
module pld_cell_fb_mux
  import pld_cell_pkg::*;
(
  input  logic [FB_SEL_W-1:0] sel_i,
  input  logic                pad_in_i,
  input  logic                q_i,
  input  logic                sum_i,
  output logic                fb_o
);
  always_comb begin
    unique case (fb_src_e'(sel_i))
      FB_FLOP: fb_o = q_i;
      FB_SUM:  fb_o = sum_i;   // taken before the pad driver
      default: fb_o = pad_in_i;
    endcase
  end
endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
  import pld_cell_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sum_i,
  input  logic                oe_term_i,
  input  logic                cfg_reg_i,
  input  logic                cfg_inv_i,
  input  logic [FB_SEL_W-1:0] fb_sel_i,
  input  logic                pad_in_i,
  output logic                pad_out_o,
  output logic                pad_oe_o,
  output logic                fb_o
);
  logic reg_q;

  pld_cell_dff #(.RESET_VAL(1'b0)) i_dff (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sum_i),
    .q_o   (reg_q)
  );

  pld_cell_drive i_drive (
    .sum_i    (sum_i),
    .q_i      (reg_q),
    .oe_term_i(oe_term_i),
    .cfg_reg_i(cfg_reg_i),
    .cfg_inv_i(cfg_inv_i),
    .pad_out_o(pad_out_o),
    .pad_oe_o (pad_oe_o)
  );

  pld_cell_fb_mux i_fb_mux (
    .sel_i   (fb_sel_i),
    .pad_in_i(pad_in_i),
    .q_i     (reg_q),
    .sum_i   (sum_i),
    .fb_o    (fb_o)
  );
endmodule

// File: rtl/pld_out_cell_chk.sv
module pld_out_cell_chk
  import pld_cell_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sum_i,
  input logic                oe_term_i,
  input logic                cfg_reg_i,
  input logic                cfg_inv_i,
  input logic [FB_SEL_W-1:0] fb_sel_i,
  input logic                pad_in_i,
  input logic                pad_out_o,
  input logic                pad_oe_o,
  input logic                fb_o,
  input logic                reg_q
);
  logic seen_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_edge <= 1'b0;
    else         seen_edge <= 1'b1;
  end

  assert_flop_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_edge |-> reg_q == $past(sum_i));

  assert_comb_path_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_reg_i |-> pad_out_o == (sum_i ^ cfg_inv_i));

  assert_reg_path_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_reg_i |-> pad_out_o == (reg_q ^ cfg_inv_i));

  assert_oe_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_oe_o == oe_term_i);

  assert_fb_pad_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_sel_i == FB_PAD || fb_sel_i == FB_PAD_ALT) |-> fb_o == pad_in_i);

  assert_fb_flop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_sel_i == FB_FLOP) |-> fb_o == reg_q);

  assert_fb_sum_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_sel_i == FB_SUM) |-> fb_o == sum_i);
endmodule

bind pld_out_cell pld_out_cell_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sum_i    (sum_i),
  .oe_term_i(oe_term_i),
  .cfg_reg_i(cfg_reg_i),
  .cfg_inv_i(cfg_inv_i),
  .fb_sel_i (fb_sel_i),
  .pad_in_i (pad_in_i),
  .pad_out_o(pad_out_o),
  .pad_oe_o (pad_oe_o),
  .fb_o     (fb_o),
  .reg_q    (reg_q)
);

// File: tb/test_pld_out_cell.sv
module test_pld_out_cell;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sum_i = 1'b0;
  logic       oe_term_i = 1'b0;
  logic       cfg_reg_i = 1'b0;
  logic       cfg_inv_i = 1'b0;
  logic [1:0] fb_sel_i = 2'b00;
  logic       pad_in_i = 1'b0;
  logic       pad_out_o, pad_oe_o, fb_o;

  int checks = 0;
  int errors = 0;
  logic model_q;

  always #10 clk_i = ~clk_i;  // 50 MHz

  pld_out_cell i_pld_out_cell (
    .clk_i(clk_i), .rst_ni(rst_ni), .sum_i(sum_i), .oe_term_i(oe_term_i),
    .cfg_reg_i(cfg_reg_i), .cfg_inv_i(cfg_inv_i), .fb_sel_i(fb_sel_i),
    .pad_in_i(pad_in_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o), .fb_o(fb_o)
  );

  // Expected flip-flop content derived from R1 and R2
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) model_q <= 1'b0;
    else         model_q <= sum_i;
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b (reg=%b inv=%b sel=%b oe=%b sum=%b pin=%b)",
               tag, act, exp, cfg_reg_i, cfg_inv_i, fb_sel_i, oe_term_i, sum_i, pad_in_i);
    end
  endtask

  task automatic check_all();
    logic exp_out, exp_fb;
    exp_out = (cfg_reg_i ? model_q : sum_i) ^ cfg_inv_i;
    if (cfg_reg_i) chk("R4 registered pad value", pad_out_o, exp_out);
    else           chk("R3 combinatorial pad value", pad_out_o, exp_out);
    chk("R5 pad enable", pad_oe_o, oe_term_i);
    case (fb_sel_i)
      2'b01: begin exp_fb = model_q;  chk("R7 flop feedback", fb_o, exp_fb); end
      2'b10: begin exp_fb = sum_i;    chk("R8 sum feedback", fb_o, exp_fb); end
      default: begin exp_fb = pad_in_i; chk("R6 pad feedback", fb_o, exp_fb); end
    endcase
  endtask

  initial begin : watchdog
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    // R1: reset state
    cfg_reg_i = 1'b1; cfg_inv_i = 1'b0; fb_sel_i = 2'b01; sum_i = 1'b1;
    repeat (2) @(posedge clk_i);
    #2;
    chk("R1 reset pad value", pad_out_o, 1'b0);
    chk("R1 reset flop feedback", fb_o, 1'b0);
    cfg_inv_i = 1'b1;
    #1 chk("R1 reset pad value inverted", pad_out_o, 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2: capture in combinatorial mode, observed through flop feedback
    cfg_reg_i = 1'b0; cfg_inv_i = 1'b0; fb_sel_i = 2'b01;
    for (int k = 0; k < 6; k++) begin
      logic prev;
      @(negedge clk_i);
      prev = sum_i;
      sum_i = k[0] ^ k[1];
      #2 chk("R2 flop holds last sampled sum", fb_o, prev);
    end

    // Sweep of every configuration against every input value
    for (int cfg = 0; cfg < 32; cfg++) begin
      @(negedge clk_i);
      cfg_reg_i = cfg[0];
      cfg_inv_i = cfg[1];
      fb_sel_i  = cfg[3:2];
      oe_term_i = cfg[4];
      for (int v = 0; v < 8; v++) begin
        logic out_a, oe_a;
        @(negedge clk_i);
        sum_i    = v[0];
        pad_in_i = v[1];
        if (v[2]) oe_term_i = ~oe_term_i;
        #2 check_all();
        out_a = pad_out_o;
        oe_a  = pad_oe_o;
        pad_in_i = ~pad_in_i;
        #1;
        chk("R9 pad out ignores pad input", pad_out_o, out_a);
        chk("R9 pad enable ignores pad input", pad_oe_o, oe_a);
        check_all();
      end
    end

    // R1: asynchronous clear mid-run
    @(negedge clk_i);
    cfg_reg_i = 1'b1; cfg_inv_i = 1'b0; fb_sel_i = 2'b01; sum_i = 1'b1;
    @(posedge clk_i);
    #3 chk("R1 flop loaded before clear", fb_o, 1'b1);
    rst_ni = 1'b0;
    #1;
    chk("R1 async clear flop feedback", fb_o, 1'b0);
    chk("R1 async clear pad value", pad_out_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule